// File: doc/BRIEF.md
# Masked Sticky Video Error Flag

This block sits behind the error detectors of a received video data path and condenses their per-category error pulses into one latched status word and one active-low error pin. It runs entirely on the pixel clock. Each error category that is enabled by a mask register sets its own status bit when it pulses. The bit then stays set until either a frame/field start strobe arrives or the host reads the status word over its serial interface. While any status bit is set, the error pin is driven low. When no status bit is set, the pin is high.

The mask register is written from the host side with a single-cycle write strobe. After reset the mask is all ones, so every category is monitored. A mask change affects only errors that arrive later. Bits that are already latched keep their value until the next clear event. When a clear and a new error coincide, the new error is kept, so no error pulse is ever lost. A host read sees the word as it was before the clear, and the clear takes effect on the following clock.

Top module: `video_err_flag`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), status_o is all zeros, err_n_o is 1, and the mask is all ones. This means a pulse on every category then sets every status bit.
- R2: A pulse on err_pulse_i bit i with mask bit i at 1 sets status_o bit i after the next rising clock edge. The bit then holds with no further pulses until a clear event. Pulses on different bits in different cycles accumulate.
- R3: err_n_o is 0 whenever any status_o bit is 1, and 1 when all status_o bits are 0.
- R4: frame_start_i high for one cycle clears every status_o bit after that clock edge, except bits that are set again by R7.
- R5: In a cycle with stat_rd_i high, status_o still shows the value from before the clear. The clear is visible after that clock edge, except for bits that are set again by R7.
- R6: A category whose mask bit is 0 never sets its status bit. mask_wr_i high loads mask_wdata_i (bit i enables category i) at that clock edge. Pulses in that same cycle are still filtered by the old mask.
- R7: A pulse on an enabled category in the same cycle as frame_start_i or stat_rd_i leaves that bit set after the edge. All other bits are cleared.
- R8: Writing the mask does not change status bits that are already set. They stay set until the next frame start or host read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_pulse_i | input | NUM_CATS | One pulse bit per error category |
| frame_start_i | input | 1 | Frame/field start strobe, clears the status word |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | NUM_CATS | New mask value, 1 = category monitored |
| stat_rd_i | input | 1 | Host read strobe for the status word, clears it |
| status_o | output | NUM_CATS | Latched error status word |
| err_n_o | output | 1 | Active-low sticky error flag |

## Verification
The bench builds the block with the default NUM_CATS of 8. This width lets it walk a single error through every category, including the top bit, and confirm that each one drives the flag on its own. It uses a split mask of 0xF0 to separate the enabled upper half from the disabled lower half in a single word. It also drives collisions between a clear and a new error, for both the frame start and the host read, so that the error-wins rule and the read-before-clear order can be checked on the same bits.

// File: rtl/vef_pkg.sv
// Package: shared constants and types for the video error flag block.
// Assumes: nothing beyond a standard SystemVerilog elaborator.
package vef_pkg;
    localparam int DEFAULT_CATS = 8;

    // Source of a clear request in a given cycle.
    typedef enum logic [1:0] {
        CLR_NONE  = 2'b00,
        CLR_FRAME = 2'b01,
        CLR_HOST  = 2'b10,
        CLR_BOTH  = 2'b11
    } clr_src_e;
endpackage

// File: rtl/vef_mask_reg.sv
// Module: holds the per-category enable mask.
// Resets to all ones and loads a new value on a write strobe.
// Assumes: rst_n is synchronous and active low.
module vef_mask_reg #(
    parameter int WIDTH = vef_pkg::DEFAULT_CATS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] mask_o
);
    localparam logic [WIDTH-1:0] ALL_ON = {WIDTH{1'b1}};

    // Mask storage: all categories enabled after reset, write replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= ALL_ON;
        else if (wr_i)
            mask_o <= wdata_i;
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mask_o == $past(wdata_i))) else $error("mask load"); // R6
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o)) else $error("mask keep"); // R8
endmodule

// File: rtl/vef_status_bit.sv
// Module: one sticky status bit for one error category.
// Sets on an enabled pulse, clears on a clear request, and set wins over clear.
// Assumes: clr_i and err_i are single-cycle strobes on the pixel clock.
module vef_status_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic err_i,
    input  logic en_i,
    input  logic clr_i,
    output logic bit_o
);
    logic hit;

    // Qualify the raw pulse with its enable bit.
    always_comb hit = err_i & en_i;

    // Sticky latch: keep the bit unless cleared, then OR in a new hit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_o <= 1'b0;
        else
            bit_o <= (bit_o & ~clr_i) | hit;
    end

    AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && en_i) |=> bit_o) else $error("set on hit"); // R2
    AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_o && !clr_i) |=> bit_o) else $error("hold"); // R8
    AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(err_i && en_i)) |=> !bit_o) else $error("clear"); // R4
    AST_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_o && !(err_i && en_i)) |=> !bit_o) else $error("masked"); // R6
    AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && err_i && en_i) |=> bit_o) else $error("collision"); // R7
endmodule

// File: rtl/vef_flag_drive.sv
// Module: combines the latched status bits into the active-low error pin.
// Assumes: the status word is registered, so the pin is glitch-free.
module vef_flag_drive #(
    parameter int WIDTH = vef_pkg::DEFAULT_CATS
) (
    input  logic [WIDTH-1:0] status_i,
    output logic             err_n_o
);
    logic any_err;

    // OR of all latched categories, inverted for the active-low pin.
    always_comb begin
        any_err = |status_i;
        err_n_o = ~any_err;
    end
endmodule

// File: rtl/video_err_flag.sv
// Module: top of the masked sticky video error flag.
// Decodes the clear sources, instantiates the mask, one sticky bit per
// category, and the flag driver.
// Assumes: all inputs are synchronous to clk, and rst_n is synchronous active low.
module video_err_flag #(
    parameter int NUM_CATS = vef_pkg::DEFAULT_CATS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CATS-1:0] err_pulse_i,
    input  logic                frame_start_i,
    input  logic                mask_wr_i,
    input  logic [NUM_CATS-1:0] mask_wdata_i,
    input  logic                stat_rd_i,
    output logic [NUM_CATS-1:0] status_o,
    output logic                err_n_o
);
    import vef_pkg::*;

    clr_src_e            clr_src;
    logic                clr_any;
    logic [NUM_CATS-1:0] mask_q;

    // Encode which clear sources are active this cycle.
    always_comb begin
        clr_src = clr_src_e'({stat_rd_i, frame_start_i});
        clr_any = (clr_src != CLR_NONE);
    end

    vef_mask_reg #(.WIDTH(NUM_CATS)) mask_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr_i),
        .wdata_i (mask_wdata_i),
        .mask_o  (mask_q)
    );

    for (genvar g = 0; g < NUM_CATS; g++) begin : g_cat
        vef_status_bit bit_i (
            .clk   (clk),
            .rst_n (rst_n),
            .err_i (err_pulse_i[g]),
            .en_i  (mask_q[g]),
            .clr_i (clr_any),
            .bit_o (status_o[g])
        );
    end

    vef_flag_drive #(.WIDTH(NUM_CATS)) flag_i (
        .status_i (status_o),
        .err_n_o  (err_n_o)
    );

    AST_FLAG_LOW_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_pulse_i & mask_q)) |=> !err_n_o) else $error("flag low"); // R3
    AST_FLAG_HIGH_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_any && !(|(err_pulse_i & mask_q))) |=> err_n_o) else $error("flag high"); // R5
endmodule

// File: tb/video_err_flag_tb_top.sv
// Bench: directed scenarios, one task each, with a small expected-value model.
module video_err_flag_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] err_pulse = '0;
    logic         frame_start = 1'b0;
    logic         mask_wr = 1'b0;
    logic [N-1:0] mask_wdata = '0;
    logic         stat_rd = 1'b0;
    logic [N-1:0] status;
    logic         err_n;

    int vectors = 0;
    int errors  = 0;
    logic [N-1:0] exp_status = '0;
    logic [N-1:0] exp_mask   = '1;

    always #2 clk = ~clk;

    video_err_flag #(.NUM_CATS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .err_pulse_i(err_pulse),
        .frame_start_i(frame_start), .mask_wr_i(mask_wr),
        .mask_wdata_i(mask_wdata), .stat_rd_i(stat_rd),
        .status_o(status), .err_n_o(err_n)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Check the word and the pin against the model.
    task automatic chk_state(input string req);
        chk(req, status, exp_status);
        chk({req, " R3 flag"}, {{(N-1){1'b0}}, err_n}, {{(N-1){1'b0}}, ~(|exp_status)});
    endtask

    // One clock: drive at the negedge, pass the posedge, update the model.
    task automatic cyc(input logic [N-1:0] p, input logic fs, input logic rd,
                       input logic mw, input logic [N-1:0] md);
        err_pulse = p; frame_start = fs; stat_rd = rd; mask_wr = mw; mask_wdata = md;
        if (rd) chk("R5 read sees old", status, exp_status);
        @(negedge clk);
        exp_status = ((fs || rd) ? '0 : exp_status) | (p & exp_mask);
        if (mw) exp_mask = md;
        err_pulse = '0; frame_start = 0; stat_rd = 0; mask_wr = 0; mask_wdata = '0;
    endtask

    task automatic idle(); cyc('0, 0, 0, 0, '0); endtask

    task automatic t_reset();
        chk_state("R1 reset");
        cyc('1, 0, 0, 0, '0);
        chk("R1 mask all ones", status, 8'hFF);
        chk_state("R1 after pulse");
        cyc('0, 1, 0, 0, '0);
        chk("R4 frame clear", status, 8'h00);
        chk_state("R4");
    endtask

    task automatic t_single();
        for (int i = 0; i < N; i++) begin
            cyc(N'(1) << i, 0, 0, 0, '0);
            chk("R2 single set", status, N'(1) << i);
            idle(); idle();
            chk_state("R2 hold");
            cyc('0, 1, 0, 0, '0);
            chk_state("R4 clear");
        end
    endtask

    task automatic t_accum();
        cyc(8'h05, 0, 0, 0, '0);
        idle();
        cyc(8'h30, 0, 0, 0, '0);
        chk("R2 accumulate", status, 8'h35);
        cyc('0, 1, 0, 0, '0);
    endtask

    task automatic t_read();
        cyc(8'h81, 0, 0, 0, '0);
        chk_state("R5 before read");
        cyc('0, 0, 1, 0, '0);
        chk("R5 cleared after read", status, 8'h00);
        chk_state("R5");
    endtask

    task automatic t_mask();
        cyc('0, 0, 0, 1, 8'hF0);
        cyc(8'h0F, 0, 0, 0, '0);
        chk("R6 masked no set", status, 8'h00);
        chk_state("R6");
        cyc(8'hFF, 0, 0, 0, '0);
        chk("R6 upper half only", status, 8'hF0);
        cyc('0, 1, 0, 0, '0);
        cyc(8'h10, 0, 0, 1, 8'h00);
        chk("R6 old mask same cycle", status, 8'h10);
        cyc(8'hFF, 0, 0, 0, '0);
        chk("R6 all masked", status, 8'h10);
        cyc('0, 0, 1, 0, '0);
        cyc('0, 0, 0, 1, 8'hFF);
    endtask

    task automatic t_keep();
        cyc(8'hF0, 0, 0, 0, '0);
        cyc('0, 0, 0, 1, 8'h00);
        idle(); idle();
        chk("R8 latched kept", status, 8'hF0);
        chk_state("R8");
        cyc('0, 1, 0, 0, '0);
        chk("R8 cleared by frame", status, 8'h00);
        cyc('0, 0, 0, 1, 8'hFF);
    endtask

    task automatic t_collide();
        cyc(8'h03, 0, 0, 0, '0);
        cyc(8'h80, 1, 0, 0, '0);
        chk("R7 frame collision", status, 8'h80);
        cyc(8'h04, 0, 1, 0, '0);
        chk("R7 read collision", status, 8'h04);
        chk_state("R7");
        cyc('0, 1, 1, 0, '0);
        chk_state("R7 both clears");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_accum();
        t_read();
        t_mask();
        t_keep();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule